// File: doc/BRIEF.md
# Programmable Binary Timer with One-Shot

This block counts clock-enable ticks in a binary ripple-style counter that is split into a lower and an upper half. Each tick stands in for one oscillator cycle. A two-bit select picks which counter stage feeds the output. For one select code, the upper half takes every tick directly instead of waiting for the lower half to wrap. This gives a short period while the mux still routes the last stage.

A mode input chooses between two behaviours. In recycle mode the output follows the chosen stage and the block divides the tick rate by a power of two. In single-cycle mode a set/reset latch flips the output once, half a period after the last clear, and then holds it. A master clear or a change of the mode level re-arms the timer. A polarity input sets the output level seen while the block is held clear. A retriggered master clear therefore acts as a one-shot whose pulse lasts half the selected period. A power-on clear request clears the block too, but only while the automatic clear is not disabled.

Top module: `prog_timer`

## Requirements
- R1: While rst_ni is low or a clear is being held, timer_o equals pol_i.
- R2: master_clr_i passes through two flops. Once synchronized, it zeroes every stage and holds the counter at zero for as long as it stays high, whatever ticks arrive.
- R3: With auto_clr_dis_i at 0, a synchronized pwr_on_req_i clears the block in the same way as the master clear.
- R4: A clear in the middle of a count restarts the count from zero, so the next output change comes half a full period after the clear is released.
- R5: Stages advance only on clk_i rising edges where tick_i is 1. Without ticks the output holds.
- R6: div_sel_i is {a,b}. Code 00 routes stage TAP_HI, code 01 routes stage TAP_MID and code 11 routes stage STAGES. The period is 2^stage ticks.
- R7: Code 10 routes stage STAGES, but the upper STAGES-LOW_W stages count every tick, so the period is 2^(STAGES-LOW_W) ticks.
- R8: With recycle_i at 1, timer_o is the routed stage XOR pol_i. Its first change comes after half a period of ticks, and it returns to pol_i after a full period.
- R9: With recycle_i at 0, timer_o becomes the inverse of pol_i after half a period of ticks and stays there through any number of further ticks.
- R10: A change of recycle_i clears the counter and the single-cycle latch. After that the count restarts from zero.
- R11: With auto_clr_dis_i at 1, pwr_on_req_i has no effect on the count or the output, and master_clr_i still clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count enable standing for an oscillator edge |
| master_clr_i | input | 1 | Asynchronous master clear request, active high |
| pwr_on_req_i | input | 1 | Asynchronous power-on clear request, active high |
| auto_clr_dis_i | input | 1 | 1 blocks the power-on clear path |
| div_sel_i | input | 2 | Stage select {a,b} |
| recycle_i | input | 1 | 1 selects recycle mode, 0 selects single-cycle mode |
| pol_i | input | 1 | Output level while the block is clear |
| timer_o | output | 1 | Timer output |

## Verification
The bench builds the block with STAGES=10, LOW_W=5, TAP_MID=6 and TAP_HI=8. This gives periods of 256, 64, 32 and 1024 ticks for codes 00, 01, 10 and 11. At these lengths the bench can run full periods for every code in both modes and both polarities, including the half-period latch point and the bypass code. The same short periods leave room to retrigger in the middle of a count, to test the power-on path with the automatic clear both enabled and disabled, and to re-arm through a mode change.

// File: rtl/prog_timer_pkg.sv
package prog_timer_pkg;
  // {a,b} stage select codes
  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_FAST  = 2'b10,
    SEL_FULL  = 2'b11
  } tap_sel_e;
endpackage

// File: rtl/prog_timer_sync.sv
module prog_timer_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/prog_timer_chain.sv
module prog_timer_chain #(
  parameter int unsigned STAGES = 16,
  parameter int unsigned LOW_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              bypass_i,
  output logic [STAGES-1:0] stages_o
);
  localparam int unsigned HI_W = STAGES - LOW_W;

  logic [LOW_W-1:0] low_q;
  logic             low_wrap;

  assign low_wrap = &low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_q <= '0;
    else if (clr_i)  low_q <= '0;
    else if (tick_i) low_q <= low_q + 1'b1;
  end

  generate
    if (HI_W > 0) begin : g_upper
      logic [HI_W-1:0] high_q;
      logic            high_adv;

      // upper half fed straight from the tick when bypassed
      assign high_adv = tick_i & (bypass_i | low_wrap);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       high_q <= '0;
        else if (clr_i)    high_q <= '0;
        else if (high_adv) high_q <= high_q + 1'b1;
      end

      assign stages_o = {high_q, low_q};
    end else begin : g_flat
      assign stages_o = low_q;
    end
  endgenerate
endmodule

// File: rtl/prog_timer_tap.sv
module prog_timer_tap
  import prog_timer_pkg::*;
#(
  parameter int unsigned STAGES  = 16,
  parameter int unsigned TAP_MID = 10,
  parameter int unsigned TAP_HI  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              hold_i,
  input  logic [STAGES-1:0] stages_i,
  input  logic [1:0]        sel_i,
  input  logic              recycle_i,
  input  logic              pol_i,
  output logic              latch_o,
  output logic              q_o
);
  logic tap_bit;
  logic latch_q;

  always_comb begin
    unique case (tap_sel_e'(sel_i))
      SEL_LONG: tap_bit = stages_i[TAP_HI-1];
      SEL_MID:  tap_bit = stages_i[TAP_MID-1];
      default:  tap_bit = stages_i[STAGES-1];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     latch_q <= 1'b0;
    else if (clr_i)                  latch_q <= 1'b0;
    else if (!recycle_i && tap_bit)  latch_q <= 1'b1;
  end

  always_comb begin
    if (hold_i)         q_o = pol_i;
    else if (recycle_i) q_o = tap_bit ^ pol_i;
    else                q_o = (latch_q | tap_bit) ^ pol_i;
  end

  assign latch_o = latch_q;
endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import prog_timer_pkg::*;
#(
  parameter int unsigned STAGES     = 16,
  parameter int unsigned LOW_W      = 8,
  parameter int unsigned TAP_MID    = 10,
  parameter int unsigned TAP_HI     = 13,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       master_clr_i,
  input  logic       pwr_on_req_i,
  input  logic       auto_clr_dis_i,
  input  logic [1:0] div_sel_i,
  input  logic       recycle_i,
  input  logic       pol_i,
  output logic       timer_o
);
  logic [1:0]        req_sync;
  logic              mclr_s, por_s;
  logic              hold, mode_chg, clr;
  logic              mode_q1, mode_q2;
  logic              latch;
  logic [STAGES-1:0] stages;

  prog_timer_sync #(.WIDTH(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({pwr_on_req_i, master_clr_i}),
    .sync_o  (req_sync)
  );

  assign mclr_s = req_sync[0];
  assign por_s  = req_sync[1];
  assign hold   = mclr_s | (por_s & ~auto_clr_dis_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q1 <= 1'b0;
      mode_q2 <= 1'b0;
    end else begin
      mode_q1 <= recycle_i;
      mode_q2 <= mode_q1;
    end
  end

  assign mode_chg = mode_q1 ^ mode_q2;
  assign clr      = hold | mode_chg;

  prog_timer_chain #(.STAGES(STAGES), .LOW_W(LOW_W)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .tick_i   (tick_i),
    .bypass_i (div_sel_i == SEL_FAST),
    .stages_o (stages)
  );

  prog_timer_tap #(.STAGES(STAGES), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI)) u_tap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .hold_i    (hold),
    .stages_i  (stages),
    .sel_i     (div_sel_i),
    .recycle_i (mode_q1),
    .pol_i     (pol_i),
    .latch_o   (latch),
    .q_o       (timer_o)
  );
endmodule

// File: rtl/prog_timer_chk.sv
module prog_timer_chk #(
  parameter int unsigned STAGES = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              master_clr_i,
  input logic              pwr_on_req_i,
  input logic              auto_clr_dis_i,
  input logic              pol_i,
  input logic              timer_o,
  input logic              hold_i,
  input logic              clr_i,
  input logic              chg_i,
  input logic              latch_i,
  input logic [STAGES-1:0] stages_i
);
  p_hold_level_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> timer_o == pol_i);

  p_mclr_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(master_clr_i, 2) |-> hold_i);

  p_por_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_on_req_i, 2) && !auto_clr_dis_i |-> hold_i);

  p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> stages_i == '0);

  p_idle_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !clr_i |=> $stable(stages_i));

  p_latch_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i && !clr_i |=> latch_i);

  p_mode_rearm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_i |=> !latch_i && stages_i == '0);

  p_por_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_clr_dis_i && !$past(master_clr_i, 2) |-> !hold_i);
endmodule

bind prog_timer prog_timer_chk #(.STAGES(STAGES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .master_clr_i   (master_clr_i),
  .pwr_on_req_i   (pwr_on_req_i),
  .auto_clr_dis_i (auto_clr_dis_i),
  .pol_i          (pol_i),
  .timer_o        (timer_o),
  .hold_i         (hold),
  .clr_i          (clr),
  .chg_i          (mode_chg),
  .latch_i        (latch),
  .stages_i       (stages)
);

// File: tb/tb_prog_timer.sv
module tb_prog_timer;
  localparam int unsigned STAGES  = 10;
  localparam int unsigned LOW_W   = 5;
  localparam int unsigned TAP_MID = 6;
  localparam int unsigned TAP_HI  = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       master_clr_i = 1'b0;
  logic       pwr_on_req_i = 1'b0;
  logic       auto_clr_dis_i = 1'b0;
  logic [1:0] div_sel_i = 2'b00;
  logic       recycle_i = 1'b1;
  logic       pol_i = 1'b0;
  logic       timer_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  prog_timer #(.STAGES(STAGES), .LOW_W(LOW_W), .TAP_MID(TAP_MID), .TAP_HI(TAP_HI)) dut (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
    .master_clr_i (master_clr_i), .pwr_on_req_i (pwr_on_req_i),
    .auto_clr_dis_i (auto_clr_dis_i), .div_sel_i (div_sel_i),
    .recycle_i (recycle_i), .pol_i (pol_i), .timer_o (timer_o)
  );

  function automatic int period(logic [1:0] code);
    case (code)
      2'b00:   return 1 << TAP_HI;
      2'b01:   return 1 << TAP_MID;
      2'b10:   return 1 << (STAGES - LOW_W);
      default: return 1 << STAGES;
    endcase
  endfunction

  task automatic check(string req, logic exp);
    total++;
    if (timer_o !== exp) begin
      bad++;
      $display("FAIL %s: timer_o=%b expected=%b sel=%b recycle=%b pol=%b",
               req, timer_o, exp, div_sel_i, recycle_i, pol_i);
    end
  endtask

  // tick high for n clock edges; returns at a negedge
  task automatic run(int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic do_clear();
    master_clr_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 level during clear", pol_i);
    master_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic t_reset();
    for (int p = 0; p < 2; p++) begin
      pol_i = p[0];
      #1;
      check("R1 reset level", pol_i);
    end
  endtask

  task automatic t_divide(logic [1:0] code, logic pol);
    int hp;
    hp = period(code) / 2;
    div_sel_i = code; pol_i = pol; recycle_i = 1'b1;
    do_clear();
    run(hp - 1); check(code == 2'b10 ? "R7 bypass before half" : "R6 R8 before half", pol);
    run(1);      check(code == 2'b10 ? "R7 bypass at half"     : "R6 R8 at half", ~pol);
    run(hp - 1); check("R8 before full", ~pol);
    run(1);      check("R8 at full period", pol);
  endtask

  task automatic t_single(logic [1:0] code, logic pol);
    int hp;
    hp = period(code) / 2;
    div_sel_i = code; pol_i = pol; recycle_i = 1'b0;
    do_clear();
    run(hp - 1);   check(code == 2'b10 ? "R7 R9 before half" : "R6 R9 before half", pol);
    run(1);        check("R9 flip at half", ~pol);
    run(2 * hp);   check("R9 held after period", ~pol);
    run(hp);       check("R9 still held", ~pol);
  endtask

  task automatic t_retrig();
    div_sel_i = 2'b01; pol_i = 1'b1; recycle_i = 1'b0;
    do_clear();
    run(20);
    master_clr_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R2 master clear mid count", 1'b1);
    run(10);
    check("R2 ticks ignored while clear held", 1'b1);
    master_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    run(31); check("R4 restart before half", 1'b1);
    run(1);  check("R4 restart at half", 1'b0);
  endtask

  task automatic t_por();
    div_sel_i = 2'b10; pol_i = 1'b0; recycle_i = 1'b0; auto_clr_dis_i = 1'b0;
    do_clear();
    run(16); check("R9 latched before power-on clear", 1'b1);
    pwr_on_req_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R3 power-on clear level", 1'b0);
    pwr_on_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R3 latch cleared", 1'b0);
    run(15); check("R3 count restarted", 1'b0);
    run(1);  check("R3 half after restart", 1'b1);
    auto_clr_dis_i = 1'b1;
    pwr_on_req_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R11 request ignored in single mode", 1'b1);
    pwr_on_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R11 latch kept", 1'b1);
    recycle_i = 1'b1;
    do_clear();
    run(10);
    pwr_on_req_i = 1'b1;
    repeat (4) @(negedge clk_i);
    pwr_on_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    run(5); check("R11 count untouched", 1'b0);
    run(1); check("R11 half reached on schedule", 1'b1);
    auto_clr_dis_i = 1'b0;
  endtask

  task automatic t_mode();
    div_sel_i = 2'b01; pol_i = 1'b0; recycle_i = 1'b0;
    do_clear();
    run(32); check("R9 latched", 1'b1);
    recycle_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R10 counter cleared on mode change", 1'b0);
    recycle_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10 latch re-armed", 1'b0);
    run(31); check("R10 before half", 1'b0);
    run(1);  check("R10 at half", 1'b1);
  endtask

  task automatic t_idle();
    div_sel_i = 2'b01; pol_i = 1'b0; recycle_i = 1'b1;
    do_clear();
    run(31);
    repeat (50) @(negedge clk_i);
    check("R5 no advance without tick", 1'b0);
    run(1);
    check("R5 advance on tick", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 2; p++) begin
        t_divide(c[1:0], p[0]);
        t_single(c[1:0], p[0]);
      end
    end
    t_retrig();
    t_por();
    t_mode();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule